// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and derives from them the node's fault confinement state. The frame processor sends it one-cycle strobes: a transmit error, a receive error, a successful transmit, a successful receive, and, for every sampled bit, a bit strobe with the sampled level. A controller reset and an init-mode flag are also inputs. From these the block produces the transmit and receive counter values for a host to read, the confinement state, the kind of error flag the frame processor must drive after a detected error, a transmit-inhibit line and a one-cycle bus-off interrupt.

The state machine has three states. ST_ACTIVE (encoding 2'b00), ST_PASSIVE (2'b01) and ST_BUSOFF (2'b10). The transitions are: T_ACT_PAS, active to passive, when either counter reaches the passive limit; T_PAS_ACT, passive to active, when both counters are back below it; T_PAS_OFF and T_ACT_OFF, to bus off, when the transmit counter goes above 255; T_OFF_ACT, bus off to active, when bus-off recovery completes. Recovery counts runs of 11 consecutive recessive sampled bits. After 128 such runs, both counters are cleared.

The counters and the state are updated together at one clock edge. The state is computed from the counter values that edge writes, so the state and the counters never disagree by a cycle.

Top module: `can_fault_guard`

## Requirements
- R1: After reset, `tec` and `rec` are 0, `conf_state` is 2'b00 (active), `err_flag_active` is 1, and `tx_block` and `busoff_irq` are 0.
- R2: A `tx_err` strobe adds 8 to `tec` and a `rx_err` strobe adds 1 to `rec`, both visible after the next clock edge. When the error strobe and the success strobe for the same counter come in the same cycle, the error wins.
- R3: A `tx_ok` strobe subtracts 1 from `tec` and a `rx_ok` strobe subtracts 1 from `rec`. A counter at 0 stays at 0.
- R4: `conf_state` is 2'b01 (passive) when either counter is at least 128 and the node is not bus off. It is 2'b00 (active) when both counters are below 128 and the node is not bus off.
- R5: When `tec` exceeds 255, `conf_state` becomes 2'b10 (bus off) and `tx_block` is 1. In bus off, all error and success strobes leave both counters unchanged.
- R6: `busoff_irq` is high for exactly the first cycle in which `conf_state` shows bus off, and low at all other times.
- R7: In bus off, a bit strobe with `bit_rec`=1 extends the current recessive run, and one with `bit_rec`=0 restarts the run. Each run of 11 completes one sequence. The bit that completes the 128th sequence clears both counters and returns the state to active at the same edge.
- R8: `err_flag_active` is 1 in the active state and 0 in the passive and bus-off states.
- R9: While `init_mode` is 1, the error and success strobes leave both counters unchanged, the recovery progress is cleared and held, and `tx_block` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| init_mode | input | 1 | Node held out of bus traffic |
| tx_err | input | 1 | Transmit error strobe |
| rx_err | input | 1 | Receive error strobe |
| tx_ok | input | 1 | Successful transmit strobe |
| rx_ok | input | 1 | Successful receive strobe |
| bit_stb | input | 1 | One pulse per sampled bus bit |
| bit_rec | input | 1 | Sampled level of that bit, 1 = recessive |
| tec | output | CNT_W (9) | Transmit error counter |
| rec | output | CNT_W (9) | Receive error counter |
| conf_state | output | 2 | 00 active, 01 passive, 10 bus off |
| err_flag_active | output | 1 | 1: drive a dominant (active) error flag; 0: drive a recessive (passive) one |
| tx_block | output | 1 | Transmission inhibited |
| busoff_irq | output | 1 | One-cycle pulse on entering bus off |

## Verification
The counters are swept one strobe at a time across the passive limit in both directions. The receive counter exposes the step of 1 and the 127/128 edge. The transmit counter exposes the step of 8 and the climb past 255 into bus off. Draining the counters past zero separates a flooring counter from a wrapping one. Same-cycle error and success pairs show which of the two wins.

Strobes are sent during init mode and during bus off, to tell ignored events from counted ones. The recovery bit stream contains a dominant bit inside a run and an init-mode interruption. Both must delay the return to active by exactly the amount the run arithmetic predicts.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'b00,
        ST_PASSIVE = 2'b01,
        ST_BUSOFF  = 2'b10
    } fc_state_t;

endpackage

// File: rtl/fcu_err_counter.sv
// Saturating error counter: add STEP on inc, subtract 1 on dec, floor at 0.
module fcu_err_counter #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d
);
    localparam logic [W:0] STEP_X = (W+1)'(STEP);

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, cnt_q} + STEP_X;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = sum[W] ? '1 : sum[W-1:0];
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    AST_INC_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt_q >= $past(cnt_q)));                        // R2
    AST_DEC_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!inc && !dec && !clr) |=> $stable(cnt_q));                        // R3

endmodule

// File: rtl/fcu_busoff_recovery.sv
// Counts runs of RUN_LEN consecutive recessive bits; done on the RUN_COUNT-th run.
module fcu_busoff_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic bit_stb,
    input  logic bit_rec,
    output logic done
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam int SW = $clog2(RUN_COUNT + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
    localparam logic [SW-1:0] SEQ_LAST = SW'(RUN_COUNT - 1);

    logic [RW-1:0] run_q;
    logic [SW-1:0] seq_q;
    logic          run_end;

    always_comb begin
        run_end = arm && bit_stb && bit_rec && (run_q == RUN_LAST);
        done    = run_end && (seq_q == SEQ_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            run_q <= '0;
            seq_q <= '0;
        end else if (bit_stb) begin
            if (!bit_rec) begin
                run_q <= '0;
            end else if (run_end) begin
                run_q <= '0;
                seq_q <= done ? '0 : seq_q + SW'(1);
            end else begin
                run_q <= run_q + RW'(1);
            end
        end
    end

    AST_RUN_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        run_q < RW'(RUN_LEN));                                             // R7
    AST_DOMINANT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !bit_rec) |=> (run_q == '0));                          // R7
    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (run_q == '0 && seq_q == '0));                            // R9

endmodule

// File: rtl/fcu_state_fsm.sv
// Three-state confinement machine driven by the counters' next values.
module fcu_state_fsm
    import fcu_pkg::*;
#(
    parameter int CW         = 9,
    parameter int PASSIVE_AT = 128,
    parameter int BUSOFF_AT  = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] tec_d,
    input  logic [CW-1:0] rec_d,
    input  logic          recovered,
    output fc_state_t     state,
    output logic          err_flag_active,
    output logic          busoff_irq
);
    localparam logic [CW-1:0] PAS_LIM = CW'(PASSIVE_AT);
    localparam logic [CW-1:0] OFF_LIM = CW'(BUSOFF_AT);

    fc_state_t state_d;
    logic      over_off;
    logic      over_pas;

    always_comb begin
        over_off = (tec_d >= OFF_LIM);
        over_pas = (tec_d >= PAS_LIM) || (rec_d >= PAS_LIM);
        state_d  = state;
        unique case (state)
            ST_ACTIVE: begin
                if (over_off)      state_d = ST_BUSOFF;   // T_ACT_OFF
                else if (over_pas) state_d = ST_PASSIVE;  // T_ACT_PAS
            end
            ST_PASSIVE: begin
                if (over_off)      state_d = ST_BUSOFF;   // T_PAS_OFF
                else if (!over_pas) state_d = ST_ACTIVE;  // T_PAS_ACT
            end
            ST_BUSOFF: begin
                if (recovered)     state_d = ST_ACTIVE;   // T_OFF_ACT
            end
            default:               state_d = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_ACTIVE;
        else     state <= state_d;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) busoff_irq <= 1'b0;
        else     busoff_irq <= (state_d == ST_BUSOFF) && (state != ST_BUSOFF);
    end

    always_comb begin
        err_flag_active = (state == ST_ACTIVE);
    end

    AST_BUSOFF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSOFF && !recovered) |=> (state == ST_BUSOFF));      // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busoff_irq |=> !busoff_irq);                                       // R6
    AST_IRQ_IN_BUSOFF: assert property (@(posedge clk) disable iff (rst)
        busoff_irq |-> (state == ST_BUSOFF));                              // R6

endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard
    import fcu_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int TX_ERR_STEP = 8,
    parameter int RX_ERR_STEP = 1,
    parameter int PASSIVE_AT  = 128,
    parameter int BUSOFF_AT   = 256,
    parameter int RUN_LEN     = 11,
    parameter int RUN_COUNT   = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_mode,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             bit_stb,
    input  logic             bit_rec,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic [1:0]       conf_state,
    output logic             err_flag_active,
    output logic             tx_block,
    output logic             busoff_irq
);
    localparam logic [CNT_W-1:0] PAS_LIM = CNT_W'(PASSIVE_AT);

    fc_state_t        state;
    logic             live;
    logic             arm;
    logic             recovered;
    logic [CNT_W-1:0] tec_d;
    logic [CNT_W-1:0] rec_d;

    always_comb begin
        live       = !init_mode && (state != ST_BUSOFF);
        arm        = !init_mode && (state == ST_BUSOFF);
        tx_block   = init_mode || (state == ST_BUSOFF);
        conf_state = state;
    end

    fcu_err_counter #(.W(CNT_W), .STEP(TX_ERR_STEP)) u_tec (
        .clk   (clk),
        .rst   (rst),
        .clr   (recovered),
        .inc   (live && tx_err),
        .dec   (live && tx_ok),
        .cnt_q (tec),
        .cnt_d (tec_d)
    );

    fcu_err_counter #(.W(CNT_W), .STEP(RX_ERR_STEP)) u_rec (
        .clk   (clk),
        .rst   (rst),
        .clr   (recovered),
        .inc   (live && rx_err),
        .dec   (live && rx_ok),
        .cnt_q (rec),
        .cnt_d (rec_d)
    );

    fcu_busoff_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .bit_stb (bit_stb),
        .bit_rec (bit_rec),
        .done    (recovered)
    );

    fcu_state_fsm #(.CW(CNT_W), .PASSIVE_AT(PASSIVE_AT), .BUSOFF_AT(BUSOFF_AT)) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .tec_d           (tec_d),
        .rec_d           (rec_d),
        .recovered       (recovered),
        .state           (state),
        .err_flag_active (err_flag_active),
        .busoff_irq      (busoff_irq)
    );

    AST_PASSIVE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASSIVE) |-> (tec >= PAS_LIM || rec >= PAS_LIM));     // R4
    AST_ACTIVE_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE) |-> (tec < PAS_LIM && rec < PAS_LIM));        // R4
    AST_INIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        init_mode |=> ($stable(tec) && $stable(rec)));                     // R9
    AST_BUSOFF_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSOFF) |=> ($stable(tec) || (tec == '0 && rec == '0))); // R5
    AST_FLAG_ONLY_BELOW: assert property (@(posedge clk) disable iff (rst)
        err_flag_active |-> (tec < PAS_LIM && rec < PAS_LIM));             // R8

endmodule

// File: tb/sim_can_fault_guard.sv
module sim_can_fault_guard;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_mode = 1'b0;
    logic       tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
    logic       bit_stb = 1'b0, bit_rec = 1'b0;
    logic [8:0] tec, rec;
    logic [1:0] conf_state;
    logic       err_flag_active, tx_block, busoff_irq;

    int checks = 0;
    int errors = 0;

    // model
    int   m_tec = 0, m_rec = 0, m_st = 0, m_run = 0, m_seq = 0;
    logic m_irq = 1'b0, m_init = 1'b0;

    always #2 clk = ~clk;

    can_fault_guard u0 (
        .clk(clk), .rst(rst), .init_mode(init_mode),
        .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .bit_stb(bit_stb), .bit_rec(bit_rec),
        .tec(tec), .rec(rec), .conf_state(conf_state),
        .err_flag_active(err_flag_active), .tx_block(tx_block),
        .busoff_irq(busoff_irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "tec", int'(tec), m_tec);
        chk(tag, "rec", int'(rec), m_rec);
        chk(tag, "conf_state", int'(conf_state), m_st);
        chk(tag, "err_flag_active", int'(err_flag_active), (m_st == 0) ? 1 : 0);
        chk(tag, "tx_block", int'(tx_block), (m_st == 2 || m_init) ? 1 : 0);
        chk(tag, "busoff_irq", int'(busoff_irq), int'(m_irq));
    endtask

    function automatic int state_of(input int t, input int r);
        if (t > 255) return 2;
        if (t >= 128 || r >= 128) return 1;
        return 0;
    endfunction

    // Called at a negedge; one event cycle.
    task automatic step(input logic te, input logic re, input logic to, input logic ro,
                        input string tag);
        int prev;
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro;
        @(posedge clk);
        prev = m_st;
        if (m_init || m_st != 2) begin m_run = 0; m_seq = 0; end
        if (!m_init && m_st != 2) begin
            if (te)                  m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
            else if (to && m_tec > 0) m_tec = m_tec - 1;
            if (re)                  m_rec = (m_rec + 1 > 511) ? 511 : m_rec + 1;
            else if (ro && m_rec > 0) m_rec = m_rec - 1;
            m_st = state_of(m_tec, m_rec);
        end
        m_irq = (m_st == 2 && prev != 2);
        @(negedge clk);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0;
        check_all(tag);
    endtask

    task automatic send_bit(input logic lvl, input string tag);
        bit_stb = 1'b1; bit_rec = lvl;
        @(posedge clk);
        if (m_init || m_st != 2) begin
            m_run = 0; m_seq = 0;
        end else if (!lvl) begin
            m_run = 0;
        end else begin
            m_run++;
            if (m_run == 11) begin
                m_run = 0;
                m_seq++;
                if (m_seq == 128) begin
                    m_seq = 0; m_tec = 0; m_rec = 0; m_st = 0;
                end
            end
        end
        m_irq = 1'b0;
        @(negedge clk);
        bit_stb = 1'b0; bit_rec = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset state");

        // R2 R4: receive counter climbs across 127/128
        for (int i = 0; i < 130; i++) step(0, 1, 0, 0, "R2 R4 rx_err sweep");
        // R3 R4: drain past zero
        for (int i = 0; i < 135; i++) step(0, 0, 0, 1, "R3 R4 rx_ok drain");

        // R2 R8: transmit counter to 128, passive flag
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, "R2 R8 tx_err sweep");
        step(0, 0, 1, 0, "R3 R4 tx_ok back to active");
        // R2 priority: error beats success on the same counter
        step(1, 0, 1, 0, "R2 tx priority");
        step(0, 1, 0, 1, "R2 rx priority");
        for (int i = 0; i < 140; i++) step(0, 0, 1, 1, "R3 drain both");

        // R9: init mode ignores strobes
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R2 pre-init");
        init_mode = 1'b1; m_init = 1'b1;
        step(1, 1, 0, 0, "R9 init errors ignored");
        step(0, 0, 1, 1, "R9 init success ignored");
        init_mode = 1'b0; m_init = 1'b0;
        step(0, 0, 0, 0, "R9 init released");

        // R5 R6: climb to bus off
        for (int i = 0; i < 40 && m_st != 2; i++) step(1, 1, 0, 0, "R5 R6 climb to bus off");
        chk("R5", "reached bus off", m_st, 2);
        step(0, 0, 0, 0, "R6 irq single pulse");
        step(1, 1, 1, 1, "R5 strobes ignored in bus off");

        // R7 R9: recovery with interruptions
        for (int i = 0; i < 5; i++) send_bit(1'b1, "R7 partial run");
        send_bit(1'b0, "R7 dominant restarts run");
        for (int i = 0; i < 30; i++) send_bit(1'b1, "R7 runs");
        init_mode = 1'b1; m_init = 1'b1;
        send_bit(1'b1, "R9 init clears recovery");
        init_mode = 1'b0; m_init = 1'b0;
        for (int i = 0; i < 1500 && m_st == 2; i++)
            send_bit(!(i == 400 || i == 777), "R7 recovery stream");
        chk("R7", "recovered state", int'(conf_state), 0);
        chk("R7", "tec cleared", int'(tec), 0);
        chk("R7", "rec cleared", int'(rec), 0);
        send_bit(1'b1, "R7 bits ignored when active");
        step(1, 0, 0, 0, "R2 counting resumes");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule